// File: doc/BRIEF.md
# Power-Up Strap Capture and Pin Role Sequencer

This block governs a small set of dual-role pins. Right after the supply becomes good, the pins act as configuration inputs: their drivers are held in high impedance, so a pull resistor on each pin can set its level. Once a fixed settling interval has passed, the block samples each pin level once and stores it. It then hands the pins over to clock duty by enabling their drivers.

The stored levels select three things: whether spread-spectrum modulation is on, whether the shared USB-rate pin runs at 48 MHz or 24 MHz, and whether any clock output is driven at all. The stored values stay locked for as long as power remains good. The only way to sample again is to drop and then restore the power-good input. The settling interval is counted in reference-clock cycles and is set by a parameter. The default of 28636 cycles is about 2 ms at 14.318 MHz.

Pin index map: strap_pin[0] is the spread-select pin, strap_pin[1] is the rate-select pin, and strap_pin[2] is the output-enable pin.

Top module: `strap_latch_seq`

## Requirements
- R1: At any clock edge where pwr_good is sampled low, the next outputs are pin_drv_en=0, all_out_en=0, cfg_spread_en=0 and cfg_sel_24m=0. The sequencer returns to waiting for power.
- R2: Call the first edge with pwr_good high edge 1. After each of edges 1 through SETTLE_CYCLES, all outputs remain 0. This keeps every pin driver in high impedance.
- R3: At edge SETTLE_CYCLES+1, the levels on strap_pin are sampled. The outputs reflect them immediately after that edge.
- R4: If strap_pin[0] was captured as 0, cfg_spread_en is 1. If it was captured as 1, cfg_spread_en is 0.
- R5: If strap_pin[1] was captured as 0, cfg_sel_24m is 0 (48 MHz). If it was captured as 1, cfg_sel_24m is 1 (24 MHz).
- R6: If strap_pin[2] was captured as 1, all_out_en is 1 and every bit of pin_drv_en is 1. If it was captured as 0, both stay 0 until power is lost.
- R7: After capture, and while pwr_good stays high, changes on strap_pin have no effect on any output.
- R8: If pwr_good drops during the settling interval, the next rise restarts the full interval of R2.
- R9: If pwr_good drops after capture, the outputs clear as in R1. The next rise performs a new capture per R2 and R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| pwr_good | input | 1 | Supply-good indication; low acts as a synchronous clear |
| strap_pin | input | NUM_PINS | Sampled levels of the dual-role pins |
| pin_drv_en | output | NUM_PINS | Per-pin driver enable; 0 means high impedance |
| all_out_en | output | 1 | Global clock output enable |
| cfg_spread_en | output | 1 | Spread-spectrum modulation enable |
| cfg_sel_24m | output | 1 | USB-rate pin select: 0 for 48 MHz, 1 for 24 MHz |

## Verification
The bench checks the window edge to the exact cycle. A timer that is off by one would either enable drivers one edge early or keep them off one edge too long. It also toggles the straps after lock. A design that failed to hold the captured values would let the configuration follow the pins.

Power is dropped both in the middle of the window and after the run state is reached. A timer that fails to restart would capture early. A lock that survives power loss would keep stale settings. All eight strap combinations are applied, so that any swapped or inverted polarity shows up on a specific output.

// File: rtl/strap_seq_pkg.sv
package strap_seq_pkg;
  typedef enum logic [1:0] {
    ST_WAIT_PWR = 2'd0,
    ST_SETTLE   = 2'd1,
    ST_RUN      = 2'd2
  } seq_state_t;

  localparam int PIN_SPREAD = 0;
  localparam int PIN_RATE   = 1;
  localparam int PIN_OE     = 2;
endpackage

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int SETTLE_CYCLES = 28636
) (
  input  logic clk,
  input  logic pwr_good,
  input  logic run,
  output logic done
);
  localparam int CNT_W = (SETTLE_CYCLES > 2) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!pwr_good || !run) cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done = run && (cnt_q == LAST);

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!pwr_good)
    cnt_q <= LAST); // R2
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import strap_seq_pkg::*;
(
  input  logic       clk,
  input  logic       pwr_good,
  input  logic       timer_done,
  output seq_state_t state,
  output logic       timer_run,
  output logic       capture
);
  seq_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_WAIT_PWR: state_d = ST_SETTLE;
      ST_SETTLE:   if (timer_done) state_d = ST_RUN;
      ST_RUN:      state_d = ST_RUN;
      default:     state_d = ST_WAIT_PWR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!pwr_good) state_q <= ST_WAIT_PWR;
    else           state_q <= state_d;
  end

  assign state     = state_q;
  assign timer_run = (state_q == ST_SETTLE);
  assign capture   = pwr_good && (state_q == ST_SETTLE) && timer_done;

  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!pwr_good)
    (state_q == ST_RUN) |=> (state_q == ST_RUN)); // R7
endmodule

// File: rtl/strap_latch.sv
module strap_latch #(
  parameter int NUM_PINS = 3
) (
  input  logic                clk,
  input  logic                pwr_good,
  input  logic                capture,
  input  logic [NUM_PINS-1:0] pin_lvl,
  output logic                locked,
  output logic [NUM_PINS-1:0] cap_bits
);
  logic locked_q;

  always_ff @(posedge clk) begin
    if (!pwr_good)    locked_q <= 1'b0;
    else if (capture) locked_q <= 1'b1;
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic bit_q;
    always_ff @(posedge clk) begin
      if (!pwr_good)                 bit_q <= 1'b0;
      else if (capture && !locked_q) bit_q <= pin_lvl[i];
    end
    assign cap_bits[i] = bit_q;
  end

  assign locked = locked_q;

  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!pwr_good)
    locked_q |=> (locked_q && $stable(cap_bits))); // R7
endmodule

// File: rtl/strap_latch_seq.sv
module strap_latch_seq
  import strap_seq_pkg::*;
#(
  parameter int SETTLE_CYCLES = 28636,
  parameter int NUM_PINS      = 3
) (
  input  logic                clk,
  input  logic                pwr_good,
  input  logic [NUM_PINS-1:0] strap_pin,
  output logic [NUM_PINS-1:0] pin_drv_en,
  output logic                all_out_en,
  output logic                cfg_spread_en,
  output logic                cfg_sel_24m
);
  seq_state_t          state;
  logic                timer_run, timer_done, capture, locked;
  logic [NUM_PINS-1:0] cap_bits;

  settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
    .clk(clk), .pwr_good(pwr_good), .run(timer_run), .done(timer_done));

  seq_fsm u_fsm (
    .clk(clk), .pwr_good(pwr_good), .timer_done(timer_done),
    .state(state), .timer_run(timer_run), .capture(capture));

  strap_latch #(.NUM_PINS(NUM_PINS)) u_latch (
    .clk(clk), .pwr_good(pwr_good), .capture(capture),
    .pin_lvl(strap_pin), .locked(locked), .cap_bits(cap_bits));

  assign all_out_en    = locked & cap_bits[PIN_OE];
  assign cfg_spread_en = locked & ~cap_bits[PIN_SPREAD];
  assign cfg_sel_24m   = locked & cap_bits[PIN_RATE];
  assign pin_drv_en    = {NUM_PINS{all_out_en}};

  AST_NO_DRIVE_EARLY: assert property (@(posedge clk) disable iff (!pwr_good)
    (state != ST_RUN) |-> (pin_drv_en == '0)); // R2
  AST_CAPTURE_FROM_SETTLE: assert property (@(posedge clk) disable iff (!pwr_good)
    $rose(locked) |-> ($past(state) == ST_SETTLE)); // R3
  AST_OE_ONLY_IN_RUN: assert property (@(posedge clk) disable iff (!pwr_good)
    all_out_en |-> (state == ST_RUN)); // R6
endmodule

// File: tb/tb_strap_latch_seq.sv
module tb_strap_latch_seq;
  localparam int N = 16;
  logic       clk = 1'b0;
  logic       pwr_good = 1'b0;
  logic [2:0] strap_pin = 3'b000;
  logic [2:0] pin_drv_en;
  logic       all_out_en, cfg_spread_en, cfg_sel_24m;
  int checks = 0;
  int errors = 0;

  strap_latch_seq #(.SETTLE_CYCLES(N), .NUM_PINS(3)) dut (
    .clk(clk), .pwr_good(pwr_good), .strap_pin(strap_pin),
    .pin_drv_en(pin_drv_en), .all_out_en(all_out_en),
    .cfg_spread_en(cfg_spread_en), .cfg_sel_24m(cfg_sel_24m));

  always #2.5 clk = ~clk;

  function automatic logic [5:0] outs();
    return {pin_drv_en, all_out_en, cfg_sel_24m, cfg_spread_en};
  endfunction

  function automatic logic [5:0] live(input logic [2:0] s);
    return {{3{s[2]}}, s[2], s[1], ~s[0]};
  endfunction

  task automatic chk(input string req, input logic [5:0] exp);
    checks++;
    if (outs() !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, outs(), exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  // Raise power with straps s; check the window (R2) and the capture edge (R3)
  task automatic power_up(input logic [2:0] s, input string req);
    int bad = 0;
    strap_pin = s;
    pwr_good  = 1'b1;
    for (int i = 1; i <= N; i++) begin
      step();
      if (outs() !== 6'b0) bad++;
    end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL R2 window cycles driven actual=%0d expected=0", bad);
    end
    step();
    chk(req, live(s));
  endtask

  task automatic t_reset();
    pwr_good = 1'b0;
    step(); step();
    chk("R1 reset state", 6'b0);
  endtask

  task automatic t_all_combos();
    for (int c = 0; c < 8; c++) begin
      power_up(3'(c), "R3 R4 R5 R6 capture decode");
      pwr_good = 1'b0;
      step();
      chk("R9 clear after power loss", 6'b0);
    end
  endtask

  task automatic t_ignore_after_lock();
    power_up(3'b110, "R3 capture before toggling");
    for (int c = 0; c < 8; c++) begin
      strap_pin = 3'(c);
      step(); step();
      chk("R7 strap change ignored", live(3'b110));
    end
    power_up_off();
  endtask

  task automatic power_up_off();
    pwr_good = 1'b0;
    step();
  endtask

  task automatic t_oe_off_stays();
    power_up(3'b011, "R6 outputs off when OE strap low");
    strap_pin = 3'b111;
    for (int i = 0; i < 3 * N; i++) step();
    chk("R6 stays off permanently", live(3'b011));
    power_up_off();
  endtask

  task automatic t_drop_in_window();
    strap_pin = 3'b101;
    pwr_good  = 1'b1;
    for (int i = 0; i < N / 2; i++) step();
    pwr_good = 1'b0;
    step();
    chk("R8 cleared on drop in window", 6'b0);
    power_up(3'b101, "R8 full window after restart");
    power_up_off();
  endtask

  task automatic t_recapture();
    power_up(3'b100, "R9 first capture");
    power_up_off();
    chk("R9 cleared", 6'b0);
    power_up(3'b001, "R9 new capture after power cycle");
    power_up_off();
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_all_combos();
    t_ignore_after_lock();
    t_oe_off_stays();
    t_drop_in_window();
    t_recapture();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule